// File: doc/BRIEF.md
# Interlocked Asynchronous Bus Master

This block carries out single read or write transfers on a master/slave bus that has no shared clock. A local client hands it an address, a size (byte or 16-bit word), a direction and, for writes, the data. The master puts address and control on the bus, raises its sync strobe, and waits for the slave's acknowledge. It then drops the strobe and waits for the acknowledge to fall before it reports the result. Each step depends only on the other side's answer, so a slow slave simply makes the transfer longer.

Memory and device registers share one address space. The block tags every access that falls in the top 4K words of the 16-bit space as a device access. A word access to an odd byte address is refused before it reaches the bus. A slave that stays silent, or one that never releases its acknowledge, ends the transfer with a timeout error. The processor traps on either error.

The incoming acknowledge passes through a synchroniser of `SYNC_STAGES` flops. The states are:
- `S_IDLE`: waits for a request.
- `S_SETUP`: address and control are driven and the strobe is low; it waits for the synchronised acknowledge to read low.
- `S_ASSERT`: the strobe is high; it waits for the acknowledge.
- `S_RELEASE`: the strobe is low; it waits for the acknowledge to drop.
- `S_FINISH`: a one-cycle done pulse.
- `S_FAULT`: a one-cycle error pulse.

The transitions are:
- `S_IDLE` goes to `S_SETUP` on an aligned request, or to `S_FAULT` on an odd word request.
- `S_SETUP` goes to `S_ASSERT` once the acknowledge reads low.
- `S_ASSERT` goes to `S_RELEASE` once the acknowledge reads high.
- `S_RELEASE` goes to `S_FINISH` once the acknowledge reads low.
- Any of the three wait states goes to `S_FAULT` when the timer expires.
- `S_FINISH` and `S_FAULT` both return to `S_IDLE`.

Top module: `async_bus_master`

## Requirements
- R1: The strobe rises only when the synchronised acknowledge reads low. It falls only after the acknowledge has been seen high, unless a timeout occurs. The address, size, direction and write data on the bus stay unchanged while the strobe is high.
- R2: After the acknowledge is seen low in `S_RELEASE`, `done` pulses for exactly one cycle. `rdata` and `dev_hit` are valid in that cycle and are held until the next request is accepted.
- R3: A word write places all 16 bits on `bus_wdata` with `bus_byte`=0. A word read returns all 16 bits of `bus_rdata`.
- R4: A byte write copies data bits 7:0 into both lanes of `bus_wdata` with `bus_byte`=1. A byte read returns bits 15:8 when address bit 0 is 1, and bits 7:0 otherwise, zero-extended to 16 bits.
- R5: If no acknowledge arrives, the strobe stays high for exactly `TIMEOUT_CYCLES` cycles. Then `err` pulses for one cycle with `err_code`=1 (timeout), and the strobe is low in that cycle.
- R6: An acknowledge that never drops also times out after `TIMEOUT_CYCLES` cycles in `S_RELEASE` or `S_SETUP`, giving `err_code`=1. A later transfer proceeds once the slave releases.
- R7: A word request with address bit 0 set gives `err` with `err_code`=2 (misaligned) in the cycle after acceptance. The strobe never rises for that request.
- R8: `dev_hit` is 1 exactly when the address is 16'hE000 or higher.
- R9: A request is accepted only in `S_IDLE`. `busy` is high from the cycle after acceptance through the done or error pulse, and is low afterwards. Requests presented while busy are ignored.
- R10: Transfers complete correctly for any acknowledge delay and release delay within the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | 16 | Byte address |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (bits 7:0 for bytes) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 0 none, 1 timeout, 2 misaligned |
| rdata | output | 16 | Read result |
| dev_hit | output | 1 | Access targeted the device page |
| bus_addr | output | 16 | Bus address |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_byte | output | 1 | Bus size, 1 = byte |
| bus_wdata | output | 16 | Bus write data |
| bus_msync | output | 1 | Master sync strobe |
| bus_rdata | input | 16 | Bus read data from slave |
| bus_ssync | input | 1 | Slave sync acknowledge |

## Verification
Inputs are driven on the falling edge and outputs are sampled on the falling edge, so the n-th sample after the accepting edge shows the state after that many rising edges.

Fixed cycle counts are checked exactly:
- A misaligned word request shows `err` on the first sample after acceptance.
- The strobe first appears on the second sample.
- On a silent slave the strobe is seen on exactly `TIMEOUT_CYCLES` samples, and `err` appears on sample `TIMEOUT_CYCLES`+2.

Normal transfers last as long as the slave's delays plus the synchroniser. For these the bench waits a bounded number of cycles for the done pulse and checks the data, device flag and bus stability in that cycle.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_ASSERT,
        S_RELEASE,
        S_FINISH,
        S_FAULT
    } bm_state_e;

    typedef enum logic [1:0] {
        E_NONE    = 2'd0,
        E_TIMEOUT = 2'd1,
        E_ODD     = 2'd2
    } bm_err_e;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/bm_timer.sv
module bm_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (run && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/bm_addr_check.sv
module bm_addr_check #(
    parameter int ADDR_W   = 16,
    parameter int DEV_BITS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_byte,
    output logic              misaligned,
    output logic              in_dev
);
    localparam logic [DEV_BITS-1:0] DEV_ONES = '1;

    assign misaligned = !is_byte && addr[0];
    assign in_dev     = (addr[ADDR_W-1 -: DEV_BITS] == DEV_ONES);
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
    import bm_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 16,
    parameter int TIMEOUT_CYCLES = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int DEV_BITS       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic [DATA_W-1:0] rdata,
    output logic              dev_hit,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_byte,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_msync,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ssync
);
    localparam int LANE_W = DATA_W / 2;

    bm_state_e state_q, state_d;
    logic      ack_s;
    logic      tmr_expired, tmr_run, tmr_clear;
    logic      chk_odd, chk_dev;
    logic      accept;

    bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(bus_ssync), .q_out(ack_s)
    );

    bm_addr_check #(.ADDR_W(ADDR_W), .DEV_BITS(DEV_BITS)) u_chk (
        .addr(req_addr), .is_byte(req_byte),
        .misaligned(chk_odd), .in_dev(chk_dev)
    );

    assign tmr_run   = (state_q == S_SETUP) || (state_q == S_ASSERT) ||
                       (state_q == S_RELEASE);
    assign tmr_clear = (state_q != state_d) || !tmr_run;

    bm_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .clear(tmr_clear),
        .expired(tmr_expired)
    );

    assign accept = (state_q == S_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = chk_odd ? S_FAULT : S_SETUP;
            S_SETUP:   if (!ack_s) state_d = S_ASSERT;
                       else if (tmr_expired) state_d = S_FAULT;
            S_ASSERT:  if (ack_s) state_d = S_RELEASE;
                       else if (tmr_expired) state_d = S_FAULT;
            S_RELEASE: if (!ack_s) state_d = S_FINISH;
                       else if (tmr_expired) state_d = S_FAULT;
            S_FINISH:  state_d = S_IDLE;
            S_FAULT:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // request capture, read capture and error code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_write <= 1'b0;
            bus_byte  <= 1'b0;
            bus_wdata <= '0;
            dev_hit   <= 1'b0;
            rdata     <= '0;
            err_code  <= E_NONE;
        end else begin
            if (accept) begin
                bus_addr  <= req_addr;
                bus_write <= req_write;
                bus_byte  <= req_byte;
                bus_wdata <= req_byte ? {2{req_wdata[LANE_W-1:0]}} : req_wdata;
                dev_hit   <= chk_dev;
                err_code  <= chk_odd ? E_ODD : E_NONE;
            end else if (state_d == S_FAULT) begin
                err_code  <= E_TIMEOUT;
            end
            if (state_q == S_ASSERT && ack_s && !bus_write) begin
                if (!bus_byte)
                    rdata <= bus_rdata;
                else if (bus_addr[0])
                    rdata <= {{(DATA_W-LANE_W){1'b0}}, bus_rdata[DATA_W-1:LANE_W]};
                else
                    rdata <= {{(DATA_W-LANE_W){1'b0}}, bus_rdata[LANE_W-1:0]};
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        bus_msync = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_SETUP:   ;
            S_ASSERT:  bus_msync = 1'b1;
            S_RELEASE: ;
            S_FINISH:  done = 1'b1;
            S_FAULT:   err = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    AST_STROBE_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_msync) |-> !ack_s) else $error("strobe rose with ack high"); // R1
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_msync && $past(bus_msync)) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write))) else $error("bus changed under strobe"); // R1
    AST_ODD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && !req_byte && req_addr[0]) |=> (err && err_code == E_ODD && !bus_msync)) else $error("odd word reached bus"); // R7
    AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ASSERT && tmr_expired && !ack_s) |=> (err && err_code == E_TIMEOUT && !bus_msync)) else $error("timeout missed"); // R5
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)) else $error("done with err"); // R2
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !err) |=> busy) else $error("busy dropped early"); // R9
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !busy) else $error("busy after pulse"); // R9
endmodule

// File: tb/tb_async_bus_master.sv
module tb_async_bus_master;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, dev_hit, bus_write, bus_byte, bus_msync;
    logic [1:0]  err_code;
    logic [15:0] rdata, bus_addr, bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ssync = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_bus_master #(.TIMEOUT_CYCLES(TO)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_byte(req_byte), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .err_code(err_code), .rdata(rdata),
        .dev_hit(dev_hit), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_msync(bus_msync),
        .bus_rdata(bus_rdata), .bus_ssync(bus_ssync)
    );

    // slave model
    logic [15:0] smem [0:127];
    int d_ack = 0, d_rel = 0, scnt = 0;
    bit mute = 0, stuck = 0, sl_phase = 0;
    int  msync_rise_ack_hi = 0, bus_change_hi = 0;
    logic prev_msync = 1'b0;
    logic [15:0] prev_addr = '0;

    initial for (int i = 0; i < 128; i++) smem[i] = 16'h0000;

    always @(negedge clk) begin
        if (bus_msync && !prev_msync && bus_ssync) msync_rise_ack_hi++;
        if (bus_msync && prev_msync && bus_addr != prev_addr) bus_change_hi++;
        prev_msync = bus_msync;
        prev_addr  = bus_addr;
        if (!sl_phase) begin
            if (bus_msync && !mute) begin
                if (scnt >= d_ack) begin
                    if (bus_write) begin
                        if (!bus_byte) smem[bus_addr[7:1]] = bus_wdata;
                        else if (bus_addr[0]) smem[bus_addr[7:1]][15:8] = bus_wdata[15:8];
                        else smem[bus_addr[7:1]][7:0] = bus_wdata[7:0];
                    end else bus_rdata = smem[bus_addr[7:1]];
                    bus_ssync = 1'b1; sl_phase = 1; scnt = 0;
                end else scnt++;
            end else scnt = 0;
        end else if (!bus_msync && !stuck) begin
            if (scnt >= d_rel) begin
                bus_ssync = 1'b0; sl_phase = 0; scnt = 0;
            end else scnt++;
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] a, input logic b, input logic w,
                        input logic [15:0] wd, output logic [15:0] rd,
                        output logic e, output logic [1:0] code, output logic dv);
        int n = 0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_byte = b; req_write = w; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        while (!done && !err && n < 200) begin @(negedge clk); n++; end
        rd = rdata; e = err; code = err_code; dv = dev_hit;
        if (!done && !err) chk("R2 completion", 0, 1);
    endtask

    logic [15:0] exp_mem [0:127];
    logic [15:0] rd, ev;
    logic        e, dv;
    logic [1:0]  code;

    initial begin
        for (int i = 0; i < 128; i++) exp_mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R5 reset msync", bus_msync, 0);
        chk("R2 reset done/err", {done, err}, 0);
        rst_n = 1;

        // R10 sweep over slave delays with R3/R4 traffic
        for (int d = 0; d < 5; d++) begin
            d_ack = d; d_rel = 4 - d;
            begin
                logic [15:0] a = 16'h0010 + 16'(4 * d);
                logic [15:0] wv = 16'hA5C3 ^ 16'(d * 16'h1111);
                xfer(a, 0, 1, wv, rd, e, code, dv);
                chk("R3 word write ok", {e, code}, 0);
                exp_mem[a[7:1]] = wv;
                xfer(a, 0, 0, 0, rd, e, code, dv);
                chk("R10 R3 word read", rd, exp_mem[a[7:1]]);
                xfer(a + 1, 1, 1, 16'h0077 + 16'(d), rd, e, code, dv);
                exp_mem[a[7:1]][15:8] = 8'h77 + 8'(d);
                chk("R4 byte write ok", {e, code}, 0);
                xfer(a, 0, 0, 0, rd, e, code, dv);
                chk("R4 byte lane high", rd, exp_mem[a[7:1]]);
                xfer(a + 1, 1, 0, 0, rd, e, code, dv);
                chk("R4 byte read odd", rd, {8'h00, exp_mem[a[7:1]][15:8]});
                xfer(a, 1, 0, 0, rd, e, code, dv);
                chk("R4 byte read even", rd, {8'h00, exp_mem[a[7:1]][7:0]});
            end
        end
        chk("R1 strobe rose with ack high", msync_rise_ack_hi, 0);
        chk("R1 bus changed under strobe", bus_change_hi, 0);

        // R8 device page boundary
        d_ack = 1; d_rel = 1;
        xfer(16'hDFFE, 0, 0, 0, rd, e, code, dv); chk("R8 below page", dv, 0);
        xfer(16'hE000, 0, 0, 0, rd, e, code, dv); chk("R8 page start", dv, 1);
        xfer(16'hFFFF, 1, 0, 0, rd, e, code, dv); chk("R8 page end", dv, 1);

        // R7 odd word address
        begin
            int rises = 0;
            @(negedge clk);
            req_valid = 1; req_addr = 16'h0033; req_byte = 0; req_write = 1;
            @(negedge clk);
            req_valid = 0;
            chk("R7 err next cycle", {err, err_code}, {1'b1, 2'd2});
            chk("R9 busy with pulse", busy, 1);
            for (int k = 0; k < 4; k++) begin
                if (bus_msync) rises++;
                @(negedge clk);
            end
            chk("R7 no strobe", rises, 0);
            chk("R9 idle after err", busy, 0);
        end

        // R5 silent slave
        begin
            int hi = 0, n = 0;
            mute = 1;
            @(negedge clk);
            req_valid = 1; req_addr = 16'h0040; req_byte = 0; req_write = 0;
            @(negedge clk);
            req_valid = 0; n = 1;
            while (!err && n < 100) begin
                if (bus_msync) hi++;
                @(negedge clk); n++;
            end
            chk("R5 strobe high cycles", hi, TO);
            chk("R5 err sample index", n, TO + 2);
            chk("R5 err code/strobe", {err_code, bus_msync}, {2'd1, 1'b0});
            mute = 0;
            repeat (4) @(negedge clk);
        end

        // R6 acknowledge stuck high
        stuck = 1;
        xfer(16'h0050, 0, 0, 0, rd, e, code, dv);
        chk("R6 stuck ack timeout", {e, code}, {1'b1, 2'd1});
        stuck = 0;
        repeat (4) @(negedge clk);
        xfer(16'h0010, 0, 0, 0, rd, e, code, dv);
        chk("R6 recovers", {e, rd}, {1'b0, exp_mem[8]});

        // R9 requests while busy are ignored
        begin
            int n = 0, bad = 0;
            d_ack = 3; d_rel = 2;
            @(negedge clk);
            req_valid = 1; req_addr = 16'h0014; req_byte = 0; req_write = 0;
            @(negedge clk);
            req_addr = 16'h0018;
            while (!done && n < 100) begin
                if (bus_addr != 16'h0014) bad++;
                @(negedge clk); n++;
            end
            req_valid = 0;
            chk("R9 addr held while busy", bad, 0);
            chk("R9 first request data", rdata, exp_mem[10]);
            @(negedge clk);
            @(negedge clk);
            chk("R9 no extra transfer", busy, 0);
        end

        summary();
    end
endmodule